// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block runs the power-up configuration sequence of a processor-style core. When the power-good input goes high, it starts a slow mode clock. The mode clock is the system clock divided by 2^DIV_LOG2 (256 by default). On each rising edge of the mode clock the block takes in one bit of a 256-bit serial configuration stream. When the last bit arrives, the block decodes the fixed-position mode fields into registered outputs in a single step. It also raises a sticky error flag if a reserved bit or a reserved code is present.

The block then releases the core's resets in order. Cold reset stays asserted for COLD_HOLD cycles after the load (more than 64K by default). Reset follows RST_GAP cycles later (more than 64 by default). After that, a warm-reset request pulls down only reset. It does not reload the stream and does not start the mode clock.

The controller has five states:
- S_LOAD: the reset state. The stream is shifted in while the mode clock runs.
- S_COLD_HOLD: cold reset and reset are both held.
- S_RST_GAP: cold reset is released and reset is still held.
- S_RUN: both resets are released.
- S_WARM: reset is held while a warm request is present.

The transitions are:
- LOAD→COLD_HOLD on the sample that completes the stream.
- COLD_HOLD→RST_GAP when the cold-hold count expires.
- RST_GAP→RUN when the gap count expires with no warm request. A warm request restarts the gap count.
- RUN→WARM when a warm request arrives.
- WARM→RST_GAP when the request drops.
- Any state returns to LOAD, asynchronously, while power-good is low.

Top module: `bootcfg_loader`

## Requirements
- R1: While loading, mode_clk has a period of 2^DIV_LOG2 clk cycles and a 50 % duty cycle. mode_clk is low after power-up until the first half period has elapsed. It is low whenever cold_rst_n is high.
- R2: mode_din is sampled at the clk edge on which mode_clk rises. The n-th sample (n = 0..255) is stream bit n.
- R3: The field outputs keep their power-up value of zero during the load. All of them update together at the edge that takes in bit 255.
- R4: The field outputs are taken from the stream as follows (the higher index is the MSB in every field):
  - xmit_pat = bits 4..1
  - clk_ratio = bits 7..5
  - big_endian = bit 8
  - wr_mode = bits 10..9
  - timer_int_off = bit 11
  - bus32 = bit 12
  - drive = bits 14..13
  - wr_delay = bits 17..15
  - fast_mul_off = bit 19
  - sys_id = bits 26..25
- R5: A 1 in any of bits 0, 18, 20..24 or 27..255 sets cfg_err at the end of the load.
- R6: Any of the following codes sets cfg_err at the end of the load: clk_ratio code 7, wr_mode code 01, or xmit_pat above 8. xmit_pat equal to 8 is legal.
- R7: cfg_err stays set until power-good drops. A later load with a clean stream leaves cfg_err at 0.
- R8: cold_rst_n is low from power-up through the load. It goes high exactly COLD_HOLD cycles after the final sample.
- R9: rst_n goes high exactly RST_GAP cycles after cold_rst_n goes high. rst_n is never high while cold_rst_n is low.
- R10: While running, a warm_req pulls rst_n low at the next edge and keeps it low while the request is held. rst_n goes high again RST_GAP cycles after the request drops. During this, cold_rst_n stays high, mode_clk stays low and the field outputs keep their values.
- R11: While pwr_good is low, the block is held in its power-up state at once, without waiting for a clk edge: cold_rst_n, rst_n, mode_clk, every field output and cfg_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Power good; low holds the block in its power-up state |
| warm_req | input | 1 | Warm-reset request |
| mode_din | input | 1 | Serial configuration data |
| mode_clk | output | 1 | Divided serial mode clock |
| cold_rst_n | output | 1 | Cold reset to the core, active low |
| rst_n | output | 1 | Reset to the core, active low |
| xmit_pat | output | 4 | Transmit data pattern code |
| clk_ratio | output | 3 | Pipeline-to-bus clock ratio code (multiplier = code + 2) |
| big_endian | output | 1 | 1 = big endian |
| wr_mode | output | 2 | Non-block write mode: 00 legacy, 10 pipelined, 11 re-issue |
| timer_int_off | output | 1 | 1 = timer interrupt disabled on interrupt line 5 |
| bus32 | output | 1 | 1 = 32-bit system interface |
| drive | output | 2 | Output drive code |
| wr_delay | output | 3 | Write address-to-data delay in bus cycles |
| fast_mul_off | output | 1 | Initial fast-multiply setting (1 = off) |
| sys_id | output | 2 | System configuration identifier |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
A controller stuck in or skipping a state shows up at the reset outputs within one clk cycle. One example is cold_rst_n rising while rst_n is already high. Another is rst_n failing to fall on the cycle after a warm request. A bit counter or shift register that is off by one shows up only at the end of the load: the field outputs take values shifted by one position, and a reserved bit can appear set, so cfg_err also goes wrong. A divider fault shows up on the very first mode_clk period as a wrong period or duty cycle. A timer fault moves the cold or reset release by a countable number of cycles.

// File: rtl/bootcfg_pkg.sv
package bootcfg_pkg;

    typedef enum logic [2:0] {
        S_LOAD,
        S_COLD_HOLD,
        S_RST_GAP,
        S_RUN,
        S_WARM
    } ldr_state_t;

    typedef struct packed {
        logic [1:0] sys_id;
        logic       fast_mul_off;
        logic [2:0] wr_delay;
        logic [1:0] drive;
        logic       bus32;
        logic       timer_int_off;
        logic [1:0] wr_mode;
        logic       big_endian;
        logic [2:0] clk_ratio;
        logic [3:0] xmit_pat;
    } mode_fields_t;

    localparam logic [2:0] RATIO_RSV   = 3'd7;
    localparam logic [1:0] WRMODE_RSV  = 2'b01;
    localparam logic [3:0] PAT_MAX_OK  = 4'd8;

endpackage

// File: rtl/bootcfg_clkdiv.sv
module bootcfg_clkdiv #(
    parameter int DIV_LOG2 = 8
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic en,
    output logic mode_clk,
    output logic rise_stb
);
    localparam int HALF_M1 = (1 << (DIV_LOG2 - 1)) - 1;

    logic [DIV_LOG2-1:0] cnt;

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good)
            cnt <= '0;
        else if (en)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    // upper counter bit is the divided clock; strobe marks its rising edge
    assign mode_clk = cnt[DIV_LOG2-1];
    assign rise_stb = en && (cnt == DIV_LOG2'(HALF_M1));
endmodule

// File: rtl/bootcfg_shifter.sv
module bootcfg_shifter #(
    parameter int NBITS = 256
) (
    input  logic             clk,
    input  logic             pwr_good,
    input  logic             stb,
    input  logic             din,
    output logic [NBITS-1:0] vec_now,
    output logic             last
);
    localparam int CW = $clog2(NBITS);

    logic [NBITS-2:0] sr;
    logic [CW-1:0]    bit_cnt;

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            sr      <= '0;
            bit_cnt <= '0;
        end else if (stb) begin
            sr      <= {din, sr[NBITS-2:1]};
            bit_cnt <= last ? '0 : bit_cnt + 1'b1;
        end
    end

    // bit 0 arrived first, so it sits at the low end; the live input is bit N-1
    assign vec_now = {din, sr};
    assign last    = stb && (bit_cnt == CW'(NBITS - 1));
endmodule

// File: rtl/bootcfg_decode.sv
module bootcfg_decode
    import bootcfg_pkg::*;
#(
    parameter int NBITS = 256
) (
    input  logic [NBITS-1:0] vec,
    output mode_fields_t     fields,
    output logic             bad
);
    function automatic logic [NBITS-1:0] rsv_mask();
        logic [NBITS-1:0] m;
        for (int i = 0; i < NBITS; i++)
            m[i] = (i == 0) || (i == 18) || (i >= 20 && i <= 24) || (i >= 27);
        return m;
    endfunction

    localparam logic [NBITS-1:0] RSV_MASK = rsv_mask();

    always_comb begin
        fields.xmit_pat      = vec[4:1];
        fields.clk_ratio     = vec[7:5];
        fields.big_endian    = vec[8];
        fields.wr_mode       = vec[10:9];
        fields.timer_int_off = vec[11];
        fields.bus32         = vec[12];
        fields.drive         = vec[14:13];
        fields.wr_delay      = vec[17:15];
        fields.fast_mul_off  = vec[19];
        fields.sys_id        = vec[26:25];
    end

    assign bad = (|(vec & RSV_MASK))
               || (fields.clk_ratio == RATIO_RSV)
               || (fields.wr_mode == WRMODE_RSV)
               || (fields.xmit_pat > PAT_MAX_OK);
endmodule

// File: rtl/bootcfg_loader.sv
module bootcfg_loader
    import bootcfg_pkg::*;
#(
    parameter int DIV_LOG2    = 8,
    parameter int STREAM_BITS = 256,
    parameter int COLD_HOLD   = 65537,
    parameter int RST_GAP     = 65
) (
    input  logic       clk,
    input  logic       pwr_good,
    input  logic       warm_req,
    input  logic       mode_din,
    output logic       mode_clk,
    output logic       cold_rst_n,
    output logic       rst_n,
    output logic [3:0] xmit_pat,
    output logic [2:0] clk_ratio,
    output logic       big_endian,
    output logic [1:0] wr_mode,
    output logic       timer_int_off,
    output logic       bus32,
    output logic [1:0] drive,
    output logic [2:0] wr_delay,
    output logic       fast_mul_off,
    output logic [1:0] sys_id,
    output logic       cfg_err
);
    localparam int TMAX = (COLD_HOLD > RST_GAP) ? COLD_HOLD : RST_GAP;
    localparam int TW   = $clog2(TMAX + 1);

    ldr_state_t       state, state_nxt;
    logic [TW-1:0]    tmr;
    logic             rise_stb, load_done, dec_bad;
    logic [STREAM_BITS-1:0] stream_vec;
    mode_fields_t     dec_fld, fld_q;

    bootcfg_clkdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk      (clk),
        .pwr_good (pwr_good),
        .en       (state == S_LOAD),
        .mode_clk (mode_clk),
        .rise_stb (rise_stb)
    );

    bootcfg_shifter #(.NBITS(STREAM_BITS)) u_shift (
        .clk      (clk),
        .pwr_good (pwr_good),
        .stb      (rise_stb),
        .din      (mode_din),
        .vec_now  (stream_vec),
        .last     (load_done)
    );

    bootcfg_decode #(.NBITS(STREAM_BITS)) u_dec (
        .vec    (stream_vec),
        .fields (dec_fld),
        .bad    (dec_bad)
    );

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_LOAD:      if (load_done) state_nxt = S_COLD_HOLD;
            S_COLD_HOLD: if (tmr == TW'(COLD_HOLD - 1)) state_nxt = S_RST_GAP;
            S_RST_GAP:   if (!warm_req && tmr == TW'(RST_GAP - 1)) state_nxt = S_RUN;
            S_RUN:       if (warm_req) state_nxt = S_WARM;
            S_WARM:      if (!warm_req) state_nxt = S_RST_GAP;
            default:     state_nxt = S_LOAD;
        endcase
    end

    // state register and phase timer
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            state <= S_LOAD;
            tmr   <= '0;
        end else begin
            state <= state_nxt;
            if (state_nxt != state || (state == S_RST_GAP && warm_req))
                tmr <= '0;
            else if (state == S_COLD_HOLD || state == S_RST_GAP)
                tmr <= tmr + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            cold_rst_n <= 1'b0;
            rst_n      <= 1'b0;
            fld_q      <= '0;
            cfg_err    <= 1'b0;
        end else begin
            cold_rst_n <= !(state_nxt == S_LOAD || state_nxt == S_COLD_HOLD);
            rst_n      <= (state_nxt == S_RUN);
            if (load_done) begin
                fld_q   <= dec_fld;
                cfg_err <= cfg_err | dec_bad;
            end
        end
    end

    assign xmit_pat      = fld_q.xmit_pat;
    assign clk_ratio     = fld_q.clk_ratio;
    assign big_endian    = fld_q.big_endian;
    assign wr_mode       = fld_q.wr_mode;
    assign timer_int_off = fld_q.timer_int_off;
    assign bus32         = fld_q.bus32;
    assign drive         = fld_q.drive;
    assign wr_delay      = fld_q.wr_delay;
    assign fast_mul_off  = fld_q.fast_mul_off;
    assign sys_id        = fld_q.sys_id;
endmodule

// File: rtl/bootcfg_loader_chk.sv
module bootcfg_loader_chk
    import bootcfg_pkg::*;
(
    input logic         clk,
    input logic         pwr_good,
    input logic         warm_req,
    input logic         mode_clk,
    input logic         cold_rst_n,
    input logic         rst_n,
    input logic         cfg_err,
    input mode_fields_t fld
);
    AST_RST_NEEDS_COLD: assert property (@(posedge clk) disable iff (!pwr_good)
        rst_n |-> cold_rst_n); // R9

    AST_COLD_RELEASE_FIRST: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(cold_rst_n) |-> !rst_n); // R9

    AST_MCLK_QUIET_AFTER_LOAD: assert property (@(posedge clk) disable iff (!pwr_good)
        cold_rst_n |-> !mode_clk); // R1

    AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!pwr_good)
        cold_rst_n |=> $stable(fld)); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!pwr_good)
        cfg_err |=> cfg_err); // R7

    AST_WARM_PULLS_RST: assert property (@(posedge clk) disable iff (!pwr_good)
        (cold_rst_n && warm_req) |=> !rst_n); // R10
endmodule

bind bootcfg_loader bootcfg_loader_chk u_chk (
    .clk        (clk),
    .pwr_good   (pwr_good),
    .warm_req   (warm_req),
    .mode_clk   (mode_clk),
    .cold_rst_n (cold_rst_n),
    .rst_n      (rst_n),
    .cfg_err    (cfg_err),
    .fld        (fld_q)
);

// File: tb/bootcfg_loader_tb.sv
`timescale 1ns/1ps
module bootcfg_loader_tb;
    localparam int DL = 2;
    localparam int NB = 256;
    localparam int CH = 40;
    localparam int RG = 9;
    localparam time MC_PER = 20;   // 4 clk cycles of 5 ns

    logic clk = 1'b0, pwr_good = 1'b0, warm_req = 1'b0, mode_din = 1'b0;
    logic mode_clk, cold_rst_n, rst_n, big_endian, timer_int_off, bus32, fast_mul_off, cfg_err;
    logic [3:0] xmit_pat;
    logic [2:0] clk_ratio, wr_delay;
    logic [1:0] wr_mode, drive, sys_id;

    int total = 0, bad = 0;
    time mc_rise = 0, mc_per = 0, mc_hi = 0;

    always #2.5 clk = ~clk;
    always @(posedge mode_clk) begin mc_per = $time - mc_rise; mc_rise = $time; end
    always @(negedge mode_clk) mc_hi = $time - mc_rise;

    bootcfg_loader #(.DIV_LOG2(DL), .STREAM_BITS(NB), .COLD_HOLD(CH), .RST_GAP(RG)) u_dut (
        .clk(clk), .pwr_good(pwr_good), .warm_req(warm_req), .mode_din(mode_din),
        .mode_clk(mode_clk), .cold_rst_n(cold_rst_n), .rst_n(rst_n),
        .xmit_pat(xmit_pat), .clk_ratio(clk_ratio), .big_endian(big_endian),
        .wr_mode(wr_mode), .timer_int_off(timer_int_off), .bus32(bus32),
        .drive(drive), .wr_delay(wr_delay), .fast_mul_off(fast_mul_off),
        .sys_id(sys_id), .cfg_err(cfg_err));

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] mk(input logic [3:0] pat, input logic [2:0] ratio,
        input logic en, input logic [1:0] wm, input logic ti, input logic b32,
        input logic [1:0] drv, input logic [2:0] wd, input logic fm, input logic [1:0] sid);
        logic [NB-1:0] v = '0;
        v[4:1] = pat; v[7:5] = ratio; v[8] = en; v[10:9] = wm; v[11] = ti;
        v[12] = b32; v[14:13] = drv; v[17:15] = wd; v[19] = fm; v[26:25] = sid;
        return v;
    endfunction

    function automatic logic [19:0] outs();
        return {sys_id, fast_mul_off, wr_delay, drive, bus32, timer_int_off,
                wr_mode, big_endian, clk_ratio, xmit_pat};
    endfunction

    function automatic logic [19:0] expect_of(input logic [NB-1:0] v);
        return {v[26:25], v[19], v[17:15], v[14:13], v[12], v[11], v[10:9], v[8], v[7:5], v[4:1]};
    endfunction

    // power cycle, stream in v, check fields and release sequence
    task automatic load(input logic [NB-1:0] v, input logic exp_err);
        int n;
        @(negedge clk) pwr_good = 1'b0; mode_din = v[0];
        repeat (3) @(negedge clk);
        pwr_good = 1'b1;
        for (int i = 0; i < NB; i++) begin
            @(posedge mode_clk);
            #1;
            if (i == 100) begin
                chk("R3", "fields during load", outs(), 0);
                chk("R8", "cold_rst_n during load", cold_rst_n, 0);
                chk("R1", "mode_clk period ns", mc_per, MC_PER);
                chk("R1", "mode_clk high ns", mc_hi, MC_PER / 2);
            end
            if (i < NB - 1) mode_din = v[i+1];
        end
        @(negedge clk);
        chk("R2/R4", "decoded fields", outs(), expect_of(v));
        chk("R5/R6", "cfg_err", cfg_err, exp_err);
        n = 0;
        while (!cold_rst_n && n < 1000) begin n++; @(negedge clk); end
        chk("R8", "cold hold cycles", n, CH);
        chk("R9", "rst_n at cold release", rst_n, 0);
        n = 0;
        while (!rst_n && n < 1000) begin n++; @(negedge clk); end
        chk("R9", "reset gap cycles", n, RG);
    endtask

    task automatic t_reset();
        #12;
        chk("R11", "cold_rst_n at power-up", cold_rst_n, 0);
        chk("R11", "rst_n at power-up", rst_n, 0);
        chk("R11", "fields at power-up", outs(), 0);
        chk("R11", "cfg_err at power-up", cfg_err, 0);
        @(negedge clk) pwr_good = 1'b1;
        @(negedge clk);
        chk("R1", "mode_clk low after power-up", mode_clk, 0);
    endtask

    task automatic t_warm();
        logic [19:0] keep = outs();
        time r0 = mc_rise;
        int n;
        @(negedge clk) warm_req = 1'b1;
        @(negedge clk);
        chk("R10", "rst_n after warm request", rst_n, 0);
        chk("R10", "cold_rst_n during warm", cold_rst_n, 1);
        repeat (5) @(negedge clk);
        warm_req = 1'b0;
        n = 0;
        @(negedge clk);
        while (!rst_n && n < 1000) begin n++; @(negedge clk); end
        chk("R10", "warm release gap", n, RG);
        chk("R10", "fields after warm", outs(), keep);
        chk("R10", "no mode_clk edge during warm", (mc_rise == r0), 1);
    endtask

    task automatic t_powerdrop();
        @(negedge clk) pwr_good = 1'b0;
        #1;
        chk("R11", "cold_rst_n on power drop", cold_rst_n, 0);
        chk("R11", "rst_n on power drop", rst_n, 0);
        chk("R11", "fields on power drop", outs(), 0);
        chk("R11", "cfg_err on power drop", cfg_err, 0);
    endtask

    logic [NB-1:0] va, vb, vx;

    initial begin
        va = mk(4'd3, 3'd2, 1'b0, 2'b10, 1'b0, 1'b1, 2'b10, 3'd5, 1'b0, 2'b01);
        vb = mk(4'd8, 3'd6, 1'b1, 2'b11, 1'b1, 1'b1, 2'b11, 3'd7, 1'b1, 2'b11);
        t_reset();
        load(va, 1'b0);                       // R2 R4
        load(vb, 1'b0);                       // R6 boundary: pattern 8 legal
        t_warm();                             // R10
        vx = va; vx[0]   = 1'b1; load(vx, 1'b1);   // R5
        vx = va; vx[18]  = 1'b1; load(vx, 1'b1);   // R5
        vx = va; vx[23]  = 1'b1; load(vx, 1'b1);   // R5
        vx = va; vx[255] = 1'b1; load(vx, 1'b1);   // R5
        load(mk(4'd3, 3'd7, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 3'd0, 1'b0, 2'b00), 1'b1); // R6
        load(mk(4'd3, 3'd1, 1'b0, 2'b01, 1'b0, 1'b0, 2'b00, 3'd0, 1'b0, 2'b00), 1'b1); // R6
        load(mk(4'd9, 3'd1, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 3'd0, 1'b0, 2'b00), 1'b1); // R6
        t_warm();
        chk("R7", "cfg_err kept through warm reset", cfg_err, 1);
        load(va, 1'b0);
        chk("R7", "cfg_err cleared by power cycle", cfg_err, 0);
        t_powerdrop();                        // R11
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #750000;
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule